// File: doc/BRIEF.md
# Indexed Display Register Port Controller

This block is the host-facing register file of a display adapter. Four sub-controllers sit behind it: a CRT timing controller, an attribute (palette/mode) controller, a sequencer and a graphics controller. Each one keeps a byte-wide register array. A host reaches these arrays through a small 8-bit I/O bus that carries a 4-bit port address, read and write strobes, and a data byte. The CRT, sequencer and graphics controllers each have an index port and a data port. The attribute controller has a single write port, and an internal phase flip-flop alternates its writes between index and data. It also has a separate read port.

All register contents are exported as flat vectors for downstream display logic. Two mode bits are decoded from the attribute mode-control register: graphics/text and 8-bit pixels. A CRT data write to either cursor-location register raises a one-cycle cursor update strobe. A single-cycle table load presets every array from a packed mode table. The sequencer's reset register is not part of that table and is forced to 0x03 on each load. The load also checks that the requested mode kind matches the table's attribute mode bit.

Top module: `disp_regport`

## Requirements
- R1: After synchronous reset every register array and every index register is zero, the attribute phase is "index", and io_rdata, io_err, cursor_upd and mode_err are 0.
- R2: For the CRT (ports 0/1), sequencer (ports 6/7) and graphics (ports 8/9) controllers, a data-port write stores into the register selected by the last index-port write. A data-port read returns that register on io_rdata one cycle after the strobe. An index-port read returns the index.
- R3: When the index is at or above the array size, a data write changes nothing and a data read returns 0x00.
- R4: Writes to port 4 alternate, starting with the index: index, data, index, data. A read of port 5 returns the attribute register selected by the attribute index.
- R5: A read of port 10 returns status_in one cycle later and puts the attribute phase back to "index".
- R6: cursor_upd pulses for one cycle after a CRT data write whose index is CUR_HI (14) or CUR_LO (15). It stays 0 after any other access.
- R7: Ports 2 and 3 accept reads and writes with no effect on any register and no error, and a read of them returns 0x00. Writes to ports 5 and 10–15, and reads of ports 4 and 11–15, raise io_err for one cycle.
- R8: A cycle with load_en high loads the arrays from load_tbl, byte k at bits 8k+7:8k. The byte order is CRT[0..N_CRT-1], then ATTR[0..N_ATTR-1], then SEQ[1..N_SEQ-1], then GFX[0..N_GFX-1]. SEQ[0] becomes 0x03.
- R9: On each load, mode_err becomes 1 when load_gfx differs from bit 0 of the table's attribute byte MODE_IDX (16); otherwise it becomes 0. It holds that value until the next load.
- R10: mode_graphics equals bit 0 and mode_8bpp equals bit 6 of attribute register MODE_IDX, tracking its current value.
- R11: Bus strobes in a cycle with load_en high are ignored: no index changes and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_err | output | 1 | Unknown-port access pulse |
| status_in | input | 8 | Status byte returned by port 10 |
| load_en | input | 1 | Mode table load strobe |
| load_gfx | input | 1 | Requested mode kind, 1 = graphics |
| load_tbl | input | 8*TBL_BYTES | Packed mode table |
| mode_err | output | 1 | Mode kind mismatch of the last load |
| cursor_upd | output | 1 | Cursor location register written |
| mode_graphics | output | 1 | Attribute mode bit 0 |
| mode_8bpp | output | 1 | Attribute mode bit 6 |
| crt_regs | output | 8*N_CRT | CRT register contents |
| attr_regs | output | 8*N_ATTR | Attribute register contents |
| seq_regs | output | 8*N_SEQ | Sequencer register contents |
| gfx_regs | output | 8*N_GFX | Graphics register contents |

## Verification
io_rdata, io_err, cursor_upd and mode_err are all registered, so each is due exactly one clock after the edge that captures its strobe or load. The exported arrays and mode bits change at that same edge. The bench applies every strobe for one cycle starting at a falling edge and reads all results at the next falling edge, which is half a period after the capturing edge. Nothing is sampled next to an active edge, and no check waits an unspecified number of cycles.

// File: rtl/disp_reg_pkg.sv
package disp_reg_pkg;

    typedef enum logic [3:0] {
        P_CRT_IDX  = 4'h0,
        P_CRT_DAT  = 4'h1,
        P_MONO_IDX = 4'h2,
        P_MONO_DAT = 4'h3,
        P_ATTR_WR  = 4'h4,
        P_ATTR_RD  = 4'h5,
        P_SEQ_IDX  = 4'h6,
        P_SEQ_DAT  = 4'h7,
        P_GFX_IDX  = 4'h8,
        P_GFX_DAT  = 4'h9,
        P_STATUS   = 4'hA
    } port_e;

    typedef struct packed {
        logic crt_idx_wr;
        logic crt_dat_wr;
        logic attr_wr;
        logic seq_idx_wr;
        logic seq_dat_wr;
        logic gfx_idx_wr;
        logic gfx_dat_wr;
        logic status_rd;
        logic unknown;
    } dec_t;

    localparam logic [7:0] SEQ_RESET_DEFAULT = 8'h03;

    function automatic logic wr_ok(input logic [3:0] a);
        return (a <= 4'h4) || (a >= 4'h6 && a <= 4'h9);
    endfunction

    function automatic logic rd_ok(input logic [3:0] a);
        return (a <= 4'h3) || (a >= 4'h5 && a <= 4'hA);
    endfunction

endpackage

// File: rtl/disp_port_dec.sv
module disp_port_dec
    import disp_reg_pkg::*;
(
    input  logic [3:0] addr,
    input  logic       rd,
    input  logic       wr,
    output dec_t       dec
);
    port_e p;
    assign p = port_e'(addr);

    always_comb begin
        dec            = '0;
        dec.crt_idx_wr = wr && (p == P_CRT_IDX);
        dec.crt_dat_wr = wr && (p == P_CRT_DAT);
        dec.attr_wr    = wr && (p == P_ATTR_WR);
        dec.seq_idx_wr = wr && (p == P_SEQ_IDX);
        dec.seq_dat_wr = wr && (p == P_SEQ_DAT);
        dec.gfx_idx_wr = wr && (p == P_GFX_IDX);
        dec.gfx_dat_wr = wr && (p == P_GFX_DAT);
        dec.status_rd  = rd && (p == P_STATUS);
        dec.unknown    = (wr && !wr_ok(addr)) || (rd && !rd_ok(addr));
    end
endmodule

// File: rtl/disp_idx_bank.sv
module disp_idx_bank #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           idx_wr,
    input  logic           dat_wr,
    input  logic [W-1:0]   din,
    input  logic           ld_en,
    input  logic [N*W-1:0] ld_vec,
    output logic [W-1:0]   idx,
    output logic [W-1:0]   sel,
    output logic [N*W-1:0] regs
);
    logic [W-1:0] arr [N];
    logic         hit;

    always_ff @(posedge clk) begin
        if (rst)         idx <= '0;
        else if (idx_wr) idx <= din;
    end

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                arr[g] <= '0;
            else if (ld_en)                         arr[g] <= ld_vec[g*W +: W];
            else if (dat_wr && (idx == W'(g)))      arr[g] <= din;
        end
        assign regs[g*W +: W] = arr[g];
    end

    always_comb begin
        sel = '0;
        hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (idx == W'(i)) begin
                sel = arr[i];
                hit = 1'b1;
            end
        end
    end

    // R2
    dat_store_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && hit && !idx_wr && !ld_en) |=> (sel == $past(din)));

    // R3
    oob_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !hit && !ld_en) |=> $stable(regs));
endmodule

// File: rtl/disp_attr_flip.sv
module disp_attr_flip (
    input  logic clk,
    input  logic rst,
    input  logic attr_wr,
    input  logic clr,
    output logic idx_wr,
    output logic dat_wr,
    output logic phase
);
    always_ff @(posedge clk) begin
        if (rst)          phase <= 1'b0;
        else if (attr_wr) phase <= ~phase;
        else if (clr)     phase <= 1'b0;
    end

    assign idx_wr = attr_wr && !phase;
    assign dat_wr = attr_wr &&  phase;

    // R4
    attr_alt_chk: assert property (@(posedge clk) disable iff (rst)
        attr_wr |=> (phase != $past(phase)));

    // R5
    status_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !attr_wr) |=> !phase);
endmodule

// File: rtl/disp_regport.sv
module disp_regport
    import disp_reg_pkg::*;
#(
    parameter int N_CRT    = 25,
    parameter int N_ATTR   = 20,
    parameter int N_SEQ    = 5,
    parameter int N_GFX    = 9,
    parameter int CUR_HI   = 14,
    parameter int CUR_LO   = 15,
    parameter int MODE_IDX = 16,
    localparam int TBL_BYTES = N_CRT + N_ATTR + N_SEQ - 1 + N_GFX
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              io_addr,
    input  logic                    io_rd,
    input  logic                    io_wr,
    input  logic [7:0]              io_wdata,
    output logic [7:0]              io_rdata,
    output logic                    io_err,
    input  logic [7:0]              status_in,
    input  logic                    load_en,
    input  logic                    load_gfx,
    input  logic [8*TBL_BYTES-1:0]  load_tbl,
    output logic                    mode_err,
    output logic                    cursor_upd,
    output logic                    mode_graphics,
    output logic                    mode_8bpp,
    output logic [8*N_CRT-1:0]      crt_regs,
    output logic [8*N_ATTR-1:0]     attr_regs,
    output logic [8*N_SEQ-1:0]      seq_regs,
    output logic [8*N_GFX-1:0]      gfx_regs
);
    localparam int ATTR_OFS = 8 * N_CRT;
    localparam int SEQ_OFS  = 8 * (N_CRT + N_ATTR);
    localparam int GFX_OFS  = 8 * (N_CRT + N_ATTR + N_SEQ - 1);
    localparam int MODE_BIT = ATTR_OFS + 8 * MODE_IDX;

    logic rd_g, wr_g;
    dec_t dec;
    assign rd_g = io_rd && !load_en;
    assign wr_g = io_wr && !load_en;

    disp_port_dec u_dec (.addr(io_addr), .rd(rd_g), .wr(wr_g), .dec(dec));

    logic a_idx_wr, a_dat_wr, a_phase;
    disp_attr_flip u_flip (
        .clk(clk), .rst(rst), .attr_wr(dec.attr_wr), .clr(dec.status_rd),
        .idx_wr(a_idx_wr), .dat_wr(a_dat_wr), .phase(a_phase)
    );

    logic [7:0] crt_idx, crt_sel, attr_idx, attr_sel;
    logic [7:0] seq_idx, seq_sel, gfx_idx, gfx_sel;
    logic [8*N_SEQ-1:0] seq_ld;
    assign seq_ld = {load_tbl[SEQ_OFS +: 8*(N_SEQ-1)], SEQ_RESET_DEFAULT};

    disp_idx_bank #(.N(N_CRT), .W(8)) u_crt (
        .clk(clk), .rst(rst), .idx_wr(dec.crt_idx_wr), .dat_wr(dec.crt_dat_wr),
        .din(io_wdata), .ld_en(load_en), .ld_vec(load_tbl[0 +: 8*N_CRT]),
        .idx(crt_idx), .sel(crt_sel), .regs(crt_regs));

    disp_idx_bank #(.N(N_ATTR), .W(8)) u_attr (
        .clk(clk), .rst(rst), .idx_wr(a_idx_wr), .dat_wr(a_dat_wr),
        .din(io_wdata), .ld_en(load_en), .ld_vec(load_tbl[ATTR_OFS +: 8*N_ATTR]),
        .idx(attr_idx), .sel(attr_sel), .regs(attr_regs));

    disp_idx_bank #(.N(N_SEQ), .W(8)) u_seq (
        .clk(clk), .rst(rst), .idx_wr(dec.seq_idx_wr), .dat_wr(dec.seq_dat_wr),
        .din(io_wdata), .ld_en(load_en), .ld_vec(seq_ld),
        .idx(seq_idx), .sel(seq_sel), .regs(seq_regs));

    disp_idx_bank #(.N(N_GFX), .W(8)) u_gfx (
        .clk(clk), .rst(rst), .idx_wr(dec.gfx_idx_wr), .dat_wr(dec.gfx_dat_wr),
        .din(io_wdata), .ld_en(load_en), .ld_vec(load_tbl[GFX_OFS +: 8*N_GFX]),
        .idx(gfx_idx), .sel(gfx_sel), .regs(gfx_regs));

    logic cur_hit;
    assign cur_hit = (crt_idx == 8'(CUR_HI)) || (crt_idx == 8'(CUR_LO));

    always_ff @(posedge clk) begin
        if (rst) begin
            io_rdata   <= '0;
            io_err     <= 1'b0;
            cursor_upd <= 1'b0;
            mode_err   <= 1'b0;
        end else begin
            io_err     <= dec.unknown;
            cursor_upd <= dec.crt_dat_wr && cur_hit;
            if (load_en)
                mode_err <= load_gfx ^ load_tbl[MODE_BIT];
            if (rd_g) begin
                case (port_e'(io_addr))
                    P_CRT_IDX: io_rdata <= crt_idx;
                    P_CRT_DAT: io_rdata <= crt_sel;
                    P_ATTR_RD: io_rdata <= attr_sel;
                    P_SEQ_IDX: io_rdata <= seq_idx;
                    P_SEQ_DAT: io_rdata <= seq_sel;
                    P_GFX_IDX: io_rdata <= gfx_idx;
                    P_GFX_DAT: io_rdata <= gfx_sel;
                    P_STATUS:  io_rdata <= status_in;
                    default:   io_rdata <= 8'h00;
                endcase
            end
        end
    end

    assign mode_graphics = attr_regs[8*MODE_IDX];
    assign mode_8bpp     = attr_regs[8*MODE_IDX + 6];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (io_rdata == 8'h00 && !io_err && !cursor_upd && !mode_err && !a_phase));

    // R6
    cursor_src_chk: assert property (@(posedge clk) disable iff (rst)
        cursor_upd |-> $past(dec.crt_dat_wr));

    // R7
    unknown_err_chk: assert property (@(posedge clk) disable iff (rst)
        dec.unknown |=> io_err);

    // R8
    seq_default_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (seq_regs[7:0] == SEQ_RESET_DEFAULT));

    // R9
    mode_err_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (mode_err == ($past(load_gfx) != $past(load_tbl[MODE_BIT]))));

    // R11
    load_idx_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> ($stable(crt_idx) && !io_err));
endmodule

// File: tb/test_disp_regport.sv
`timescale 1ns/1ps
module test_disp_regport;
    localparam int NC = 25, NA = 20, NS = 5, NG = 9;
    localparam int TB = NC + NA + NS - 1 + NG;
    localparam int MI = 16;

    logic clk = 0, rst = 1;
    logic [3:0] io_addr = 0;
    logic io_rd = 0, io_wr = 0, load_en = 0, load_gfx = 0;
    logic [7:0] io_wdata = 0, status_in = 0, io_rdata;
    logic [8*TB-1:0] load_tbl = '0;
    logic io_err, mode_err, cursor_upd, mode_graphics, mode_8bpp;
    logic [8*NC-1:0] crt_regs;
    logic [8*NA-1:0] attr_regs;
    logic [8*NS-1:0] seq_regs;
    logic [8*NG-1:0] gfx_regs;

    disp_regport i_disp_regport (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_err(io_err),
        .status_in(status_in), .load_en(load_en), .load_gfx(load_gfx),
        .load_tbl(load_tbl), .mode_err(mode_err), .cursor_upd(cursor_upd),
        .mode_graphics(mode_graphics), .mode_8bpp(mode_8bpp),
        .crt_regs(crt_regs), .attr_regs(attr_regs), .seq_regs(seq_regs),
        .gfx_regs(gfx_regs));

    always #4 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic err_s, cur_s;
    logic [7:0] rv;
    logic [7:0] crt_m [NC];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk); io_wr = 0; err_s = io_err; cur_s = cursor_upd;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_rd = 1;
        @(negedge clk); io_rd = 0; d = io_rdata; err_s = io_err; cur_s = cursor_upd;
    endtask

    function automatic logic [7:0] pat(input int b, input int i);
        return 8'((b * 64 + i * 5 + 1) & 255);
    endfunction

    // sweep one index/data bank: ports ip/dp, size n, bank code b
    task automatic sweep(input logic [3:0] ip, input logic [3:0] dp, input int n, input int b);
        for (int i = 0; i < n; i++) begin
            wr(ip, 8'(i));
            check("R6 no strobe on index write", {31'b0, cur_s}, 0);
            wr(dp, pat(b, i));
            if (b == 0) begin
                crt_m[i] = pat(b, i);
                check("R6 cursor strobe", {31'b0, cur_s}, {31'b0, (i == 14 || i == 15)});
            end else
                check("R6 no strobe outside CRT", {31'b0, cur_s}, 0);
        end
        for (int i = 0; i < n; i++) begin
            wr(ip, 8'(i));
            rd(ip, rv);
            check("R2 index readback", {24'b0, rv}, i);
            rd(dp, rv);
            check("R2 data readback", {24'b0, rv}, {24'b0, pat(b, i)});
            check("R2 no error", {31'b0, err_s}, 0);
        end
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 rdata", {24'b0, io_rdata}, 0);
        check("R1 flags", {28'b0, io_err, cursor_upd, mode_err, mode_graphics}, 0);
        check("R1 crt", {31'b0, |crt_regs}, 0);
        check("R1 attr/seq/gfx", {29'b0, |attr_regs, |seq_regs, |gfx_regs}, 0);
        rd(4'h0, rv);
        check("R1 crt index zero", {24'b0, rv}, 0);

        // R2 / R6 sweeps
        sweep(4'h0, 4'h1, NC, 0);
        sweep(4'h6, 4'h7, NS, 1);
        sweep(4'h8, 4'h9, NG, 2);
        for (int i = 0; i < NC; i++)
            check("R2 crt export", {24'b0, crt_regs[8*i +: 8]}, {24'b0, crt_m[i]});

        // R3 out of range index
        wr(4'h0, 8'd200);
        wr(4'h1, 8'hEE);
        check("R3 no cursor strobe", {31'b0, cur_s}, 0);
        rd(4'h1, rv);
        check("R3 oob read", {24'b0, rv}, 0);
        for (int i = 0; i < NC; i++)
            check("R3 crt untouched", {24'b0, crt_regs[8*i +: 8]}, {24'b0, crt_m[i]});
        wr(4'h6, 8'd5);
        wr(4'h7, 8'h5A);
        rd(4'h7, rv);
        check("R3 seq oob read", {24'b0, rv}, 0);

        // R4 attribute alternating writes, first write is index
        for (int i = 0; i < NA; i++) begin
            wr(4'h4, 8'(i));
            wr(4'h4, pat(3, i));
        end
        for (int i = 0; i < NA; i++)
            check("R4 attr export", {24'b0, attr_regs[8*i +: 8]}, {24'b0, pat(3, i)});
        for (int i = 0; i < NA; i++) begin
            status_in = 8'(i * 11 + 2);
            rd(4'hA, rv);
            check("R5 status value", {24'b0, rv}, i * 11 + 2);
            wr(4'h4, 8'(i));
            rd(4'h5, rv);
            check("R4 attr readback", {24'b0, rv}, {24'b0, pat(3, i)});
        end
        // R5 status read returns phase to index: phase now data
        rd(4'hA, rv);
        wr(4'h4, 8'd7);
        wr(4'h4, 8'h99);
        check("R5 phase reset", {24'b0, attr_regs[8*7 +: 8]}, 32'h99);

        // R10 mode bits
        wr(4'h4, 8'(MI)); wr(4'h4, 8'h41);
        check("R10 gfx+8bpp", {30'b0, mode_graphics, mode_8bpp}, 2'b11);
        wr(4'h4, 8'(MI)); wr(4'h4, 8'h40);
        check("R10 text+8bpp", {30'b0, mode_graphics, mode_8bpp}, 2'b01);
        wr(4'h4, 8'(MI)); wr(4'h4, 8'h01);
        check("R10 gfx+4bpp", {30'b0, mode_graphics, mode_8bpp}, 2'b10);

        // R7 mono ports ignored
        wr(4'h0, 8'd3);
        wr(4'h2, 8'h77); check("R7 mono idx no err", {31'b0, err_s}, 0);
        wr(4'h3, 8'h77); check("R7 mono dat no err", {31'b0, err_s}, 0);
        rd(4'h3, rv);    check("R7 mono read zero", {24'b0, rv}, 0);
        check("R7 mono read no err", {31'b0, err_s}, 0);
        rd(4'h0, rv);    check("R7 crt index kept", {24'b0, rv}, 3);
        for (int i = 0; i < NC; i++)
            check("R7 crt untouched", {24'b0, crt_regs[8*i +: 8]}, {24'b0, crt_m[i]});
        // R7 address sweep
        for (int a = 0; a < 16; a++) begin
            wr(4'(a), 8'h00);
            check("R7 write err", {31'b0, err_s},
                  {31'b0, !((a <= 4) || (a >= 6 && a <= 9))});
        end
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), rv);
            check("R7 read err", {31'b0, err_s},
                  {31'b0, !((a <= 3) || (a >= 5 && a <= 10))});
        end

        // R8 / R9 / R11 table loads
        for (int k = 0; k < 4; k++) begin
            logic bit0, gfx;
            bit0 = k[0]; gfx = k[1];
            for (int j = 0; j < TB; j++) load_tbl[8*j +: 8] = 8'((j * 7 + 3 + k) & 255);
            load_tbl[8*(NC + MI) +: 8] = {7'b0, bit0};
            wr(4'h0, 8'd9);
            @(negedge clk);
            load_en = 1; load_gfx = gfx;
            io_addr = 4'h0; io_wdata = 8'h33; io_wr = 1;
            @(negedge clk);
            load_en = 0; io_wr = 0;
            check("R9 mode_err", {31'b0, mode_err}, {31'b0, gfx ^ bit0});
            check("R11 no err during load", {31'b0, io_err}, 0);
            check("R8 seq reset default", {24'b0, seq_regs[7:0]}, 32'h03);
            for (int j = 0; j < NC; j++)
                check("R8 crt load", {24'b0, crt_regs[8*j +: 8]}, {24'b0, load_tbl[8*j +: 8]});
            for (int j = 0; j < NA; j++)
                check("R8 attr load", {24'b0, attr_regs[8*j +: 8]}, {24'b0, load_tbl[8*(NC+j) +: 8]});
            for (int j = 1; j < NS; j++)
                check("R8 seq load", {24'b0, seq_regs[8*j +: 8]}, {24'b0, load_tbl[8*(NC+NA+j-1) +: 8]});
            for (int j = 0; j < NG; j++)
                check("R8 gfx load", {24'b0, gfx_regs[8*j +: 8]}, {24'b0, load_tbl[8*(NC+NA+NS-1+j) +: 8]});
            check("R10 mode bit after load", {31'b0, mode_graphics}, {31'b0, bit0});
            rd(4'h0, rv);
            check("R11 index unchanged", {24'b0, rv}, 9);
            wr(4'h0, 8'd1);
            check("R9 mode_err held", {31'b0, mode_err}, {31'b0, gfx ^ bit0});
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule